// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns one 6-bit operand code of a 16-bit processor into an operand descriptor. The descriptor names what the operand is: a general register, a memory address, the stack pointer, the program counter, the overflow register, or a constant. It also carries a register index, an address or a value. The block owns the program counter and the stack pointer. It performs the side effects a mode needs: it fetches an extension word at PC and then advances PC, and it moves SP for the pop and push modes. Reading or writing the final operand is left to the instruction datapath that uses the descriptor.

A code enters on a valid/ready handshake (`in_valid`, `in_ready`). A code is accepted on a rising edge where both are high. `in_ready` falls while an extension word is being fetched, and that is the only back-pressure. For codes that need no extension word, `done` and the descriptor appear combinationally in the accept cycle. For codes that need one, the block raises `mem_req` with `mem_addr` = PC from the next cycle on. It holds both until `mem_ack`, and it presents `done` in the acknowledge cycle. General registers are read through a combinational port (`reg_sel` → `reg_data`).

Top module: `opnd_decoder`

## Requirements
- R1: After reset, PC and SP are 0, `in_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: Descriptor kind encoding: register 0, memory 1, SP 2, PC 3, overflow 4, literal 5. Codes 0x00–0x07 give kind register with value n. Codes 0x08–0x0F give kind memory with address equal to register n-8.
- R3: Codes 0x10–0x17 read the word at PC and then increment PC. They give kind memory with address (word + register n-0x10) mod 65536.
- R4: Code 0x18 gives memory at SP, then SP increments. Code 0x19 gives memory at SP and leaves SP unchanged. Code 0x1A decrements SP and gives memory at the new SP. All SP changes wrap modulo 65536.
- R5: Code 0x1B gives kind SP with the current SP as value. Code 0x1C gives kind PC with the current PC. Code 0x1D gives kind overflow with value 0.
- R6: Code 0x1E reads the word at PC (PC then increments) and gives kind memory at that word. Code 0x1F does the same but gives kind literal with the word as value.
- R7: Codes 0x20–0x3F give kind literal with value code-0x20 (0 to 31).
- R8: `desc_extra` is 1 exactly for codes 0x10–0x17, 0x1E and 0x1F. These are the codes that cost one extra cycle.
- R9: Codes without an extension word raise `done` in the accept cycle and issue no memory read. Fetching codes issue exactly one read, hold `mem_req` and `mem_addr` steady until `mem_ack`, keep `in_ready` low meanwhile, and raise `done` in the acknowledge cycle.
- R10: `desc_ro` (a write to this operand must be ignored) is 1 exactly when the kind is literal.
- R11: PC changes only in a cycle where `mem_req` and `mem_ack` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand code offered |
| in_ready | output | 1 | Block can accept a code |
| in_code | input | 6 | Operand code |
| reg_sel | output | 3 | General register index to read |
| reg_data | input | 16 | Content of the selected register |
| mem_req | output | 1 | Extension word read request |
| mem_addr | output | 16 | Read address (current PC) |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Descriptor valid this cycle |
| desc_kind | output | 3 | Descriptor kind (see R2) |
| desc_val | output | 16 | Register index, address or value |
| desc_extra | output | 1 | Code costs one extra cycle |
| desc_ro | output | 1 | Write to this operand is ignored |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
Directed cases cover the stack wrap points, where a push from SP 0 must land on 0xFFFF and a pop from 0xFFFF must return to 0. They also cover an indexed sum that overflows 16 bits, the literal ends 0x20 and 0x3F, and the special registers. Together these separate correct modular arithmetic from off-by-one or pre/post-update mistakes. A random stream of all 64 codes, with random register contents and acknowledge delays of 0 to 3 cycles, exercises handshake holding and PC tracking across long mixed sequences. A reference model compares every descriptor field, PC and SP after each operand.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int CODE_W = 6;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_REG = 3'd0, K_MEM = 3'd1, K_SP = 3'd2,
    K_PC  = 3'd3, K_OVF = 3'd4, K_LIT = 3'd5
  } kind_t;

  typedef enum logic [3:0] {
    C_REG, C_IND, C_IDX, C_POP, C_PEEK, C_PUSH,
    C_SPV, C_PCV, C_OVF, C_NWMEM, C_NWLIT, C_SLIT
  } mode_t;
endpackage

// File: rtl/opnd_classify.sv
module opnd_classify
  import opnd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output mode_t             mode,
  output logic              fetch
);
  always_comb begin
    if (code[5])               mode = C_SLIT;
    else if (code[4:3] == 2'b00) mode = C_REG;
    else if (code[4:3] == 2'b01) mode = C_IND;
    else if (code[4:3] == 2'b10) mode = C_IDX;
    else begin
      case (code[2:0])
        3'd0:    mode = C_POP;
        3'd1:    mode = C_PEEK;
        3'd2:    mode = C_PUSH;
        3'd3:    mode = C_SPV;
        3'd4:    mode = C_PCV;
        3'd5:    mode = C_OVF;
        3'd6:    mode = C_NWMEM;
        default: mode = C_NWLIT;
      endcase
    end
    fetch = (mode == C_IDX) || (mode == C_NWMEM) || (mode == C_NWLIT);
  end
endmodule

// File: rtl/opnd_sp_unit.sv
module opnd_sp_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] sp_dec
);
  assign sp_dec = sp - DW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= '0;
    else if (inc) sp <= sp + DW'(1);
    else if (dec) sp <= sp_dec;
  end

  // R4
  sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc || dec) |=> $stable(sp));
  // R4
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (sp == $past(sp) - DW'(1)));
endmodule

// File: rtl/opnd_fetch_ctl.sv
module opnd_fetch_ctl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          mem_ack,
  output logic          busy,
  output logic [DW-1:0] pc,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr
);
  assign mem_req  = busy;
  assign mem_addr = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pc   <= '0;
    end else if (busy) begin
      if (mem_ack) begin
        busy <= 1'b0;
        pc   <= pc + DW'(1);
      end
    end else if (launch) begin
      busy <= 1'b1;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R11
  pc_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack) |=> $stable(pc));
  // R3
  pc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (pc == $past(pc) + DW'(1)));
endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
  import opnd_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic [RW-1:0]     reg_sel,
  input  logic [DW-1:0]     reg_data,
  output logic              mem_req,
  output logic [DW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic [KIND_W-1:0] desc_kind,
  output logic [DW-1:0]     desc_val,
  output logic              desc_extra,
  output logic              desc_ro,
  output logic [DW-1:0]     pc,
  output logic [DW-1:0]     sp
);
  logic [CODE_W-1:0] held_code, cur_code;
  logic              busy, accept, launch, fetch;
  logic [DW-1:0]     sp_dec;
  mode_t             mode;
  kind_t             kind;

  assign cur_code = busy ? held_code : in_code;
  assign reg_sel  = cur_code[RW-1:0];
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign launch   = accept && fetch;
  assign done     = (accept && !fetch) || (busy && mem_ack);

  always_ff @(posedge clk) begin
    if (!rst_n)      held_code <= '0;
    else if (launch) held_code <= in_code;
  end

  opnd_classify u_cls (.code(cur_code), .mode(mode), .fetch(fetch));

  opnd_sp_unit #(.DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .inc(accept && mode == C_POP),
    .dec(accept && mode == C_PUSH),
    .sp(sp), .sp_dec(sp_dec)
  );

  opnd_fetch_ctl #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .mem_ack(mem_ack),
    .busy(busy), .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  always_comb begin
    kind     = K_MEM;
    desc_val = '0;
    case (mode)
      C_REG:   begin kind = K_REG; desc_val = DW'(cur_code[RW-1:0]); end
      C_IND:   desc_val = reg_data;
      C_IDX:   desc_val = mem_rdata + reg_data;
      C_POP,
      C_PEEK:  desc_val = sp;
      C_PUSH:  desc_val = sp_dec;
      C_SPV:   begin kind = K_SP;  desc_val = sp; end
      C_PCV:   begin kind = K_PC;  desc_val = pc; end
      C_OVF:   kind = K_OVF;
      C_NWMEM: desc_val = mem_rdata;
      C_NWLIT: begin kind = K_LIT; desc_val = mem_rdata; end
      default: begin kind = K_LIT; desc_val = DW'(cur_code[4:0]); end
    endcase
  end

  assign desc_kind  = kind;
  assign desc_extra = fetch;
  assign desc_ro    = (kind == K_LIT);

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> mem_req);
  // R9
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);
  // R10
  lit_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && desc_kind == 3'd5) |-> desc_ro);
endmodule

// File: tb/sim_opnd_decoder.sv
`timescale 1ns/1ps
module sim_opnd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_code = '0;
  logic [2:0]  reg_sel;
  logic [15:0] reg_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic [2:0]  desc_kind;
  logic [15:0] desc_val;
  logic        desc_extra, desc_ro;
  logic [15:0] pc, sp;

  logic [15:0] regs [8];
  logic [15:0] pc_m = '0, sp_m = '0;
  int checks = 0, errors = 0;

  assign reg_data = regs[reg_sel];

  always #2.5 clk = ~clk;

  opnd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .reg_sel(reg_sel), .reg_data(reg_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .desc_kind(desc_kind),
    .desc_val(desc_val), .desc_extra(desc_extra), .desc_ro(desc_ro),
    .pc(pc), .sp(sp)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic needs_word(input logic [5:0] c);
    return (c[5:3] == 3'b010) || (c == 6'h1E) || (c == 6'h1F);
  endfunction

  // expected kind and value from the requirements
  function automatic void expect_desc(input logic [5:0] c, input logic [15:0] r,
      input logic [15:0] s, input logic [15:0] p, input logic [15:0] w,
      output logic [2:0] k, output logic [15:0] v);
    k = 3'd1; v = 16'h0;
    if (c >= 6'h20)      begin k = 3'd5; v = 16'(c - 6'h20); end
    else if (c < 6'h08)  begin k = 3'd0; v = 16'(c); end
    else if (c < 6'h10)  v = r;
    else if (c < 6'h18)  v = w + r;
    else case (c)
      6'h18, 6'h19: v = s;
      6'h1A: v = s - 16'd1;
      6'h1B: begin k = 3'd2; v = s; end
      6'h1C: begin k = 3'd3; v = p; end
      6'h1D: begin k = 3'd4; v = 16'h0; end
      6'h1E: v = w;
      default: begin k = 3'd5; v = w; end
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_desc(input logic [5:0] c, input logic [15:0] w);
    logic [2:0] k; logic [15:0] v;
    expect_desc(c, regs[c[2:0]], sp_m, pc_m, w, k, v);
    chk("R9 done", 32'(done), 32'd1);
    chk(c >= 6'h20 ? "R7 kind" : "R2 kind", 32'(desc_kind), 32'(k));
    chk(c[5:4] == 2'b01 && c < 6'h18 ? "R3 val" :
        (c >= 6'h18 && c <= 6'h1A) ? "R4 val" :
        (c >= 6'h1B && c <= 6'h1D) ? "R5 val" :
        (c == 6'h1E || c == 6'h1F) ? "R6 val" : "R2 val", 32'(desc_val), 32'(v));
    chk("R8 extra", 32'(desc_extra), 32'(needs_word(c)));
    chk("R10 ro", 32'(desc_ro), 32'(k == 3'd5));
  endtask

  task automatic do_op(input logic [5:0] c, input int lat);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; mem_ack = 1'b0;
    #1;
    chk("R9 ready", 32'(in_ready), 32'd1);
    if (!needs_word(c)) begin
      check_desc(c, 16'h0);
      chk("R9 noreq", 32'(mem_req), 32'd0);
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (c == 6'h18) sp_m = sp_m + 16'd1;
      if (c == 6'h1A) sp_m = sp_m - 16'd1;
    end else begin
      chk("R9 early", 32'(done), 32'd0);
      @(posedge clk); #1;
      in_valid = 1'b0;
      for (int i = 0; i <= lat; i++) begin
        @(negedge clk);
        mem_ack = (i == lat);
        mem_rdata = memf(mem_addr);
        #1;
        chk("R9 req", 32'(mem_req), 32'd1);
        chk("R3 addr", 32'(mem_addr), 32'(pc_m));
        chk("R9 busy", 32'(in_ready), 32'd0);
        if (i == lat) check_desc(c, memf(pc_m));
        else chk("R9 wait", 32'(done), 32'd0);
        @(posedge clk);
      end
      #1; mem_ack = 1'b0;
      pc_m = pc_m + 16'd1;
    end
    #0.5;
    chk("R11 pc", 32'(pc), 32'(pc_m));
    chk("R4 sp", 32'(sp), 32'(sp_m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) regs[i] = 16'h1000 * 16'(i) + 16'h0F0F;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pc", 32'(pc), 32'd0);
    chk("R1 sp", 32'(sp), 32'd0);
    chk("R1 ready", 32'(in_ready), 32'd1);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;

    // directed corners
    do_op(6'h1A, 0);           // R4 push wraps SP 0 -> FFFF
    do_op(6'h19, 0);           // R4 peek
    do_op(6'h18, 0);           // R4 pop wraps back to 0
    regs[5] = 16'hFFF0;
    do_op(6'h15, 2);           // R3 indexed sum wraps
    do_op(6'h1F, 0);           // R6 literal word
    do_op(6'h1E, 3);           // R6 memory at word
    do_op(6'h20, 0);           // R7 low end
    do_op(6'h3F, 0);           // R7 high end
    do_op(6'h1B, 0);           // R5 SP
    do_op(6'h1C, 0);           // R5 PC
    do_op(6'h1D, 0);           // R5 overflow
    do_op(6'h03, 0);           // R2 register
    do_op(6'h0B, 0);           // R2 indirect

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
      do_op(6'($urandom_range(0, 63)), int'($urandom_range(0, 3)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule